// File: doc/BRIEF.md
# Streaming Lifting Wavelet Transform (one dimension)

This block performs a one-level, one-dimensional discrete wavelet transform on a stream of signed samples. It uses the lifting factorisation. Samples arrive one per clock over a valid/ready handshake. They are paired into even and odd branches, and the pairs pass through four lifting steps. Two of the steps refine the odd branch from its even neighbours. The other two refine the even branch from its odd neighbours. A final step scales the two branches by a gain and by its reciprocal. The results leave as one stream that alternates low-pass and high-pass coefficients.

Each step talks to the next only through a small FIFO. A step keeps the one neighbour it still needs in a register of its own. As a result the data dependence between steps never forms a long combinational chain, and the block sustains one sample per cycle under backpressure. A position counter finds the first and last sample pair of each line. At those edges the missing neighbour is taken by symmetric extension.

Top module: `dwt_lift_1d`

## Requirements
- R1: Reset is synchronous and active-low. In the first cycle after reset, `m_valid` is 0 and `s_ready` is 1.
- R2: The block emits exactly one output word for each accepted input sample. Words alternate low, high, low, high, starting with low. `m_high` is 0 on a low-pass word and 1 on a high-pass word. Output pair k of a line is built from input samples 2k and 2k+1.
- R3: Coefficients are signed 16-bit values with 12 fractional bits. Each lifting step computes y = x1 + round((x0 + x2) * coef / 4096), rounding half up, and the result is saturated to 16 bits. In that step, x1 is the sample being updated and x0 and x2 are its neighbours on the other branch. The steps run in this order: odd update with `coef_a`, even update with `coef_b`, odd update with `coef_c`, even update with `coef_d`. Interior results lie within ±2 LSB of a real-valued model of the same chain.
- R4: At a line edge the missing neighbour repeats the nearest sample of the same branch. An odd-branch update of the last pair uses that pair's even value twice. An even-branch update of the first pair uses that pair's odd value twice.
- R5: After the fourth step, the low-pass word is round(even * `coef_k` / 4096). The high-pass word is round(odd * `coef_kinv` / 4096).
- R6: Every result saturates to the range -32768..32767 instead of wrapping.
- R7: While `m_valid` is 1 and `m_ready` is 0, `m_valid`, `m_data` and `m_high` hold steady. No word is lost or duplicated under any stall pattern. While `m_ready` stays 1, `s_ready` stays 1, so one sample is accepted per cycle.
- R8: A sample presented with `s_sol` high is taken as position 0 of a line. Without `s_sol`, the position counter wraps after `LINE_LEN` samples and the next sample begins a new line with its own edge handling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| coef_a | input | 16 | First odd-branch lifting coefficient, Q4.12 |
| coef_b | input | 16 | First even-branch lifting coefficient, Q4.12 |
| coef_c | input | 16 | Second odd-branch lifting coefficient, Q4.12 |
| coef_d | input | 16 | Second even-branch lifting coefficient, Q4.12 |
| coef_k | input | 16 | Low-pass gain, Q4.12 |
| coef_kinv | input | 16 | High-pass gain (reciprocal of the low-pass gain), Q4.12 |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high together with s_valid |
| s_data | input | 16 | Signed input sample |
| s_sol | input | 1 | Marks the sample as the first of a line |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream ready |
| m_data | output | 16 | Signed output coefficient |
| m_high | output | 1 | 0 for a low-pass word, 1 for a high-pass word |

## Verification
The bench builds the block with `LINE_LEN` = 8 and a FIFO depth of 2. With only four pairs per line, every line contains both edge pairs and two interior pairs. Several lines then fit in each scenario, so the position counter wrap and the symmetric extension at both ends come up many times. The shallow FIFOs fill within a few stalled cycles, so random backpressure reaches the full and empty states of every stage boundary.

// File: rtl/dwt_lift_pkg.sv
package dwt_lift_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int SAMPLE_W = 16;
  localparam int COEF_W   = 16;
  localparam int FRAC_W   = 12;

  typedef logic signed [SAMPLE_W-1:0] smp_t;
  typedef logic signed [COEF_W-1:0]   coef_t;

  // one even/odd sample pair plus its line-edge markers
  typedef struct packed {
    smp_t ev;
    smp_t od;
    logic first;
    logic last;
  } pair_t;

  function automatic smp_t sat_smp(longint v);
    longint hi = (longint'(1) <<< (SAMPLE_W-1)) - 1;
    longint lo = -hi - 1;
    if (v > hi) return smp_t'(hi);
    if (v < lo) return smp_t'(lo);
    return smp_t'(v);
  endfunction

  // fixed-point gain, rounding half up
  function automatic smp_t fx_mul(smp_t x, coef_t k);
    longint p = longint'(x) * longint'(k);
    return sat_smp((p + (longint'(1) <<< (FRAC_W-1))) >>> FRAC_W);
  endfunction

  // one lifting step: x1 + (x0 + x2) * k
  function automatic smp_t lift_mac(smp_t x0, smp_t x2, smp_t x1, coef_t k);
    longint s = longint'(x0) + longint'(x2);
    longint p = s * longint'(k);
    return sat_smp(longint'(x1) + ((p + (longint'(1) <<< (FRAC_W-1))) >>> FRAC_W));
  endfunction
endpackage

// File: rtl/dwt_pair_fifo.sv
module dwt_pair_fifo
  import dwt_lift_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  pair_t in_data,
  output logic  out_valid,
  input  logic  out_ready,
  output pair_t out_data
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  pair_t         mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign in_ready  = (cnt != CW'(DEPTH));
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + PW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/dwt_lift_split.sv
module dwt_lift_split
  import dwt_lift_pkg::*;
#(
  parameter int LINE_LEN = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  s_valid,
  output logic  s_ready,
  input  smp_t  s_data,
  input  logic  s_sol,
  output logic  out_valid,
  input  logic  out_ready,
  output pair_t out_data
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = $clog2(LINE_LEN);

  logic [PW-1:0] pos_q, idx;
  smp_t          ev_q;
  pair_t         pr_q;
  logic          pv_q, take, at_end;

  assign s_ready   = !pv_q || out_ready;
  assign take      = s_valid && s_ready;
  assign idx       = s_sol ? '0 : pos_q;   // start-of-line forces position 0
  assign at_end    = (idx == PW'(LINE_LEN-1));
  assign out_valid = pv_q;
  assign out_data  = pr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      pv_q  <= 1'b0;
      ev_q  <= '0;
      pr_q  <= '0;
    end else begin
      if (pv_q && out_ready) pv_q <= 1'b0;
      if (take) begin
        pos_q <= at_end ? '0 : idx + PW'(1);
        if (!idx[0]) begin
          ev_q <= s_data;
        end else begin
          pv_q <= 1'b1;
          pr_q <= '{ev: ev_q, od: s_data, first: (idx == PW'(1)), last: at_end};
        end
      end
    end
  end
endmodule

// File: rtl/dwt_lift_step.sv
module dwt_lift_step
  import dwt_lift_pkg::*;
#(
  parameter bit ODD_SIDE = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  coef_t coef,
  input  logic  in_valid,
  output logic  in_ready,
  input  pair_t in_data,
  output logic  out_valid,
  input  logic  out_ready,
  output pair_t out_data
);
  timeunit 1ns;
  timeprecision 1ps;

  generate
    if (ODD_SIDE) begin : g_odd
      // odd[n] needs even[n+1]: hold pair n until pair n+1 (or line end)
      pair_t hold_q;
      logic  hv_q, fire;
      smp_t  right_ev;

      assign right_ev  = hold_q.last ? hold_q.ev : in_data.ev;
      assign out_valid = hv_q && (hold_q.last || in_valid);
      assign fire      = out_valid && out_ready;
      assign in_ready  = !hv_q || fire;

      always_comb begin
        out_data    = hold_q;
        out_data.od = lift_mac(hold_q.ev, right_ev, hold_q.od, coef);
      end

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          hv_q   <= 1'b0;
          hold_q <= '0;
        end else if (in_valid && in_ready) begin
          hv_q   <= 1'b1;
          hold_q <= in_data;
        end else if (fire) begin
          hv_q   <= 1'b0;
        end
      end
    end else begin : g_even
      // even[n] needs odd[n-1]: keep last odd value as history
      smp_t prev_od_q, left_od;

      assign left_od   = in_data.first ? in_data.od : prev_od_q;
      assign out_valid = in_valid;
      assign in_ready  = out_ready;

      always_comb begin
        out_data    = in_data;
        out_data.ev = lift_mac(left_od, in_data.od, in_data.ev, coef);
      end

      always_ff @(posedge clk) begin
        if (!rst_n)                  prev_od_q <= '0;
        else if (in_valid && in_ready) prev_od_q <= in_data.od;
      end
    end
  endgenerate
endmodule

// File: rtl/dwt_lift_merge.sv
module dwt_lift_merge
  import dwt_lift_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  coef_t coef_k,
  input  coef_t coef_kinv,
  input  logic  in_valid,
  output logic  in_ready,
  input  pair_t in_data,
  output logic  m_valid,
  input  logic  m_ready,
  output smp_t  m_data,
  output logic  m_high
);
  timeunit 1ns;
  timeprecision 1ps;

  pair_t p_q;
  logic  pv_q, hi_q, fire;

  assign m_valid  = pv_q;
  assign m_high   = hi_q;
  assign m_data   = hi_q ? fx_mul(p_q.od, coef_kinv) : fx_mul(p_q.ev, coef_k);
  assign fire     = pv_q && m_ready;
  assign in_ready = !pv_q || (fire && hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      hi_q <= 1'b0;
      p_q  <= '0;
    end else begin
      if (fire) hi_q <= !hi_q;
      if (in_valid && in_ready) begin
        p_q  <= in_data;
        pv_q <= 1'b1;
      end else if (fire && hi_q) begin
        pv_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dwt_lift_1d.sv
module dwt_lift_1d
  import dwt_lift_pkg::*;
#(
  parameter int LINE_LEN   = 64,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic signed [COEF_W-1:0]   coef_a,
  input  logic signed [COEF_W-1:0]   coef_b,
  input  logic signed [COEF_W-1:0]   coef_c,
  input  logic signed [COEF_W-1:0]   coef_d,
  input  logic signed [COEF_W-1:0]   coef_k,
  input  logic signed [COEF_W-1:0]   coef_kinv,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_data,
  input  logic                       s_sol,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic signed [SAMPLE_W-1:0] m_data,
  output logic                       m_high
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NSTEP = 4;
  localparam int NFIFO = NSTEP + 1;

  coef_t coefs [NSTEP];
  assign coefs[0] = coef_a;
  assign coefs[1] = coef_b;
  assign coefs[2] = coef_c;
  assign coefs[3] = coef_d;

  logic  fi_v [NFIFO];
  logic  fi_r [NFIFO];
  pair_t fi_d [NFIFO];
  logic  fo_v [NFIFO];
  logic  fo_r [NFIFO];
  pair_t fo_d [NFIFO];

  dwt_lift_split #(.LINE_LEN(LINE_LEN)) split_i (
    .clk, .rst_n, .s_valid, .s_ready, .s_data, .s_sol,
    .out_valid(fi_v[0]), .out_ready(fi_r[0]), .out_data(fi_d[0])
  );

  for (genvar f = 0; f < NFIFO; f++) begin : g_fifo
    dwt_pair_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i (
      .clk, .rst_n,
      .in_valid(fi_v[f]), .in_ready(fi_r[f]), .in_data(fi_d[f]),
      .out_valid(fo_v[f]), .out_ready(fo_r[f]), .out_data(fo_d[f])
    );
  end

  // steps alternate: odd-branch update, then even-branch update
  for (genvar s = 0; s < NSTEP; s++) begin : g_step
    dwt_lift_step #(.ODD_SIDE((s % 2) == 0)) step_i (
      .clk, .rst_n, .coef(coefs[s]),
      .in_valid(fo_v[s]), .in_ready(fo_r[s]), .in_data(fo_d[s]),
      .out_valid(fi_v[s+1]), .out_ready(fi_r[s+1]), .out_data(fi_d[s+1])
    );
  end

  dwt_lift_merge merge_i (
    .clk, .rst_n, .coef_k, .coef_kinv,
    .in_valid(fo_v[NSTEP]), .in_ready(fo_r[NSTEP]), .in_data(fo_d[NSTEP]),
    .m_valid, .m_ready, .m_data, .m_high
  );
endmodule

// File: rtl/dwt_lift_chk.sv
module dwt_lift_chk
  import dwt_lift_pkg::*;
(
  input logic clk,
  input logic rst_n,
  input logic s_valid,
  input logic s_ready,
  input logic m_valid,
  input logic m_ready,
  input smp_t m_data,
  input logic m_high
);
  timeunit 1ns;
  timeprecision 1ps;

  int unsigned n_in, n_out;
  logic        exp_high;
  logic        in_take, out_take;

  assign in_take  = s_valid && s_ready;
  assign out_take = m_valid && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_in     <= 0;
      n_out    <= 0;
      exp_high <= 1'b0;
    end else begin
      if (in_take) n_in <= n_in + 1;
      if (out_take) begin
        n_out    <= n_out + 1;
        exp_high <= !exp_high;
      end
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !m_valid);

  assert_low_high_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> (m_high == exp_high));

  assert_no_extra_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_take |-> (n_out < n_in));

  assert_hold_under_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_high)));
endmodule

bind dwt_lift_1d dwt_lift_chk chk_i (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_high(m_high)
);

// File: tb/dwt_lift_1d_tb_top.sv
module dwt_lift_1d_tb_top;
  import dwt_lift_pkg::*;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LN = 8;
  localparam int NP = LN / 2;

  logic  clk = 1'b0, rst_n = 1'b0;
  coef_t ca = '0, cb = '0, cc = '0, cd = '0, ck = 16'sd4096, cki = 16'sd4096;
  logic  s_valid = 1'b0, s_sol = 1'b0, m_ready = 1'b1;
  smp_t  s_data = '0;
  logic  s_ready, m_valid, m_high;
  smp_t  m_data;

  always #10 clk = ~clk;

  dwt_lift_1d #(.LINE_LEN(LN), .FIFO_DEPTH(2)) dut_i (
    .clk, .rst_n, .coef_a(ca), .coef_b(cb), .coef_c(cc), .coef_d(cd),
    .coef_k(ck), .coef_kinv(cki), .s_valid, .s_ready, .s_data, .s_sol,
    .m_valid, .m_ready, .m_data, .m_high
  );

  int n_chk = 0, n_bad = 0, cyc = 0, stall_pct = 0;
  logic took = 1'b0;
  int got_q[$];
  bit hi_q[$];

  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk) took <= s_valid && s_ready;
  always @(posedge clk)
    if (rst_n && m_valid && m_ready) begin
      got_q.push_back(int'(m_data));
      hi_q.push_back(m_high);
    end
  always @(posedge clk) begin
    #1 m_ready = ($urandom_range(99) >= stall_pct);
  end

  task automatic check(string req, bit ok, real act, real exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0.2f expected %0.2f", req, act, exp);
    end
  endtask

  function automatic real clamp(real v);
    if (v > 32767.0) return 32767.0;
    if (v < -32768.0) return -32768.0;
    return v;
  endfunction

  // real-valued lifting chain with mirrored edges
  function automatic void model_line(int xs[$], int base, ref real ex[$]);
    real e[NP], o[NP], e2[NP];
    real ra = real'(ca) / 4096.0, rb = real'(cb) / 4096.0;
    real rc = real'(cc) / 4096.0, rd = real'(cd) / 4096.0;
    for (int i = 0; i < NP; i++) begin
      e[i] = real'(xs[base + 2*i]);
      o[i] = real'(xs[base + 2*i + 1]);
    end
    for (int i = 0; i < NP; i++) o[i] += ra * (e[i] + e[(i == NP-1) ? i : i+1]);
    for (int i = 0; i < NP; i++) e2[i] = e[i] + rb * (o[(i == 0) ? i : i-1] + o[i]);
    for (int i = 0; i < NP; i++) o[i] += rc * (e2[i] + e2[(i == NP-1) ? i : i+1]);
    for (int i = 0; i < NP; i++) e[i] = e2[i] + rd * (o[(i == 0) ? i : i-1] + o[i]);
    for (int i = 0; i < NP; i++) begin
      ex.push_back(clamp(e[i] * real'(ck) / 4096.0));
      ex.push_back(clamp(o[i] * real'(cki) / 4096.0));
    end
  endfunction

  task automatic stream_check(int xs[$], bit sol_each, int stall, string tag, real tol);
    real ex[$];
    int first_c = 0, last_c = 0;
    for (int l = 0; l < xs.size() / LN; l++) model_line(xs, l * LN, ex);
    got_q.delete();
    hi_q.delete();
    stall_pct = stall;
    @(negedge clk);
    for (int k = 0; k < xs.size(); k++) begin
      s_valid = 1'b1;
      s_data  = smp_t'(xs[k]);
      s_sol   = ((k % LN) == 0) && (sol_each || k == 0);
      forever begin
        @(posedge clk);
        #2;
        if (took) break;
      end
      if (k == 0) first_c = cyc;
      last_c = cyc;
    end
    s_valid = 1'b0;
    s_sol   = 1'b0;
    if (stall == 0)  // R7: full rate while downstream never stalls
      check("R7 throughput", (last_c - first_c) == xs.size() - 1,
            real'(last_c - first_c), real'(xs.size() - 1));
    for (int t = 0; t < 3000 && got_q.size() < xs.size(); t++) @(posedge clk);
    repeat (20) @(posedge clk);
    #2;
    check("R2 word count", got_q.size() == xs.size(), real'(got_q.size()), real'(xs.size()));
    for (int j = 0; j < got_q.size() && j < ex.size(); j++) begin
      int p = (j / 2) % NP;
      string r = (tag != "R6" && (p == 0 || p == NP-1)) ? "R4 edge" : tag;
      real d = real'(got_q[j]) - ex[j];
      check("R2 low/high order", hi_q[j] == bit'(j % 2), real'(hi_q[j]), real'(j % 2));
      check(r, (d <= tol) && (d >= -tol), real'(got_q[j]), ex[j]);
    end
    stall_pct = 0;
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 m_valid after reset", m_valid == 1'b0, real'(m_valid), 0.0);
    check("R1 s_ready after reset", s_ready == 1'b1, real'(s_ready), 1.0);
  endtask

  // R8: only the first line carries s_sol; later lines rely on the wrap
  task automatic test_ramp_wrap();
    int xs[$];
    ca = -16'sd2048; cb = 16'sd1024; cc = '0; cd = '0; ck = 16'sd4096; cki = 16'sd4096;
    for (int k = 0; k < 3 * LN; k++) xs.push_back(k * 37 - 300 + ((k % 3) * 90));
    stream_check(xs, 1'b0, 0, "R8", 2.0);
  endtask

  // R3 + R7: all four steps, random data, random stalls
  task automatic test_lift_stall();
    int xs[$];
    ca = -16'sd2048; cb = 16'sd1024; cc = 16'sd1024; cd = -16'sd512; ck = 16'sd4096; cki = 16'sd4096;
    for (int k = 0; k < 6 * LN; k++) xs.push_back(int'($urandom_range(2000)) - 1000);
    stream_check(xs, 1'b1, 40, "R3", 2.0);
  endtask

  // R5: gains only
  task automatic test_scale();
    int xs[$];
    ca = '0; cb = '0; cc = '0; cd = '0; ck = 16'sd5120; cki = 16'sd3072;
    for (int k = 0; k < 2 * LN; k++) xs.push_back(int'($urandom_range(4000)) - 2000);
    stream_check(xs, 1'b1, 25, "R5", 1.0);
  endtask

  // R6: gains of 2 push both branches past full scale
  task automatic test_saturate();
    int xs[$];
    ca = '0; cb = '0; cc = '0; cd = '0; ck = 16'sd8192; cki = 16'sd8192;
    for (int k = 0; k < LN; k++) xs.push_back((k % 2 == 0) ? 30000 : -30000);
    stream_check(xs, 1'b1, 0, "R6", 0.0);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    test_reset();
    test_ramp_wrap();
    test_lift_stall();
    test_scale();
    test_saturate();
    summary();
    $finish;
  end
endmodule